// File: doc/BRIEF.md
# Peak and Negative-Delta Voltage Terminator

This block watches the averaged cell-voltage samples that arrive during a fast charge and decides when the voltage has turned over. It keeps the highest in-window sample seen since its history was last erased. When a later sample falls far enough below that peak, it raises a terminate flag. The flag stays set until the controller starts a new charge cycle.

Two drop thresholds are available. The three-level mode input picks one of them, and it also sets how long the hold-off lasts after fast charge begins. While the hold-off runs, detection is masked, but the stored peak keeps following the samples. Only samples that lie strictly between 1000 mV and 2000 mV take part. A separate history-clear pulse discards the stored peak without touching the flag or the hold-off timer. Hold-off time is counted in pulses of an external time-base tick.

Top module: `vdrop_terminator`

## Requirements
- R1: After reset, and on the clock edge where `cycle_start` is high, `term_o` goes to 0, `peak_valid_o` goes to 0 and the hold-off timer restarts from zero, so `holdoff_busy_o` is 1. A tick in that same cycle is not counted.
- R2: An accepted sample is stored as the peak if no peak is held, or if it is greater than the stored peak. A sample that is not greater leaves the peak unchanged. The new peak is visible on `peak_mv_o` one clock after the sample.
- R3: When `mode_sel[1]` is 1 (codes 2'b10 and 2'b11), the block uses negative-delta mode. An accepted sample at least 12 mV below the stored peak sets `term_o` on the next clock. A drop of 11 mV does not.
- R4: When `mode_sel` is 2'b00 (low) or 2'b01 (mid), the block uses peak-detect mode with a 2.5 mV threshold compared at 0.1 mV resolution. For integer-millivolt samples this means a drop of 3 mV sets `term_o` and a drop of 2 mV does not.
- R5: A sample counts only when it satisfies 1000 < `sample_mv` < 2000. Any other sample neither changes the peak nor sets `term_o`.
- R6: The hold-off lasts 300 ticks for mid, 150 ticks for low and 75 ticks for high. `holdoff_busy_o` falls on the clock that counts the last of these ticks.
- R7: While `holdoff_busy_o` is 1, no sample can set `term_o`, but accepted samples still update the peak.
- R8: Once set, `term_o` stays set until `cycle_start`, whatever samples, ticks or history clears arrive.
- R9: `hist_clr` drops the stored peak on the next clock. The first accepted sample after that becomes the new peak. `hist_clr` does not affect `term_o` or the hold-off timer.
- R10: A sample that arrives in the same cycle as `hist_clr` or `cycle_start` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_start | input | 1 | Start of a new fast-charge cycle: clears flag and history, restarts hold-off |
| hist_clr | input | 1 | Erase the stored peak only |
| tick | input | 1 | Time-base pulse counted by the hold-off timer |
| mode_sel | input | 2 | 00 low, 01 mid, 1x high (negative-delta) |
| sample_vld | input | 1 | Strobe for `sample_mv` |
| sample_mv | input | 12 | Averaged cell voltage, unsigned millivolts |
| term_o | output | 1 | Sticky voltage-termination flag |
| peak_mv_o | output | 12 | Stored peak sample |
| peak_valid_o | output | 1 | A peak is held |
| holdoff_busy_o | output | 1 | Hold-off in progress, detection masked |

## Verification
Every registered result appears one clock after the edge that samples its cause. `term_o`, `peak_mv_o` and `peak_valid_o` reflect a sample, a history clear or a cycle start from the edge that captures it. `holdoff_busy_o` falls right after the edge that counts the final tick. The bench drives each stimulus for exactly one clock, waits 1 ns past that edge and reads the outputs there, before it drives anything else. For the hold-off, it checks `holdoff_busy_o` after one tick fewer than the limit and again after the last tick.

// File: rtl/vterm_pkg.sv
package vterm_pkg;

    parameter int MV_W = 12;

    typedef enum logic [1:0] {
        TM_LOW  = 2'b00,
        TM_MID  = 2'b01,
        TM_HIGH = 2'b10,
        TM_HIGX = 2'b11
    } tm_sel_e;

    typedef struct packed {
        logic            valid;
        logic [MV_W-1:0] mv;
    } peak_t;

    function automatic logic is_neg_delta(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/vterm_holdoff.sv
module vterm_holdoff
    import vterm_pkg::*;
#(
    parameter int LIM_LOW  = 150,
    parameter int LIM_MID  = 300,
    parameter int LIM_HIGH = 75
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       tick,
    input  logic [1:0] mode,
    output logic       busy
);
    localparam int MAXA = (LIM_LOW > LIM_MID) ? LIM_LOW : LIM_MID;
    localparam int MAXL = (MAXA > LIM_HIGH) ? MAXA : LIM_HIGH;
    localparam int CW   = $clog2(MAXL + 1);
    localparam logic [CW-1:0] L_LOW  = CW'(LIM_LOW);
    localparam logic [CW-1:0] L_MID  = CW'(LIM_MID);
    localparam logic [CW-1:0] L_HIGH = CW'(LIM_HIGH);
    localparam logic [CW-1:0] L_MAX  = CW'(MAXL);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_comb begin
        if (is_neg_delta(mode))      limit = L_HIGH;
        else if (mode == TM_MID)     limit = L_MID;
        else                         limit = L_LOW;
    end

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (tick && cnt < limit)
            cnt <= cnt + 1'b1;
    end

    assign busy = (cnt < limit);

    // R6: counter never passes the longest hold-off
    always_ff @(posedge clk) begin
        if (!rst) p_cnt_bound_r6: assert (cnt <= L_MAX);
    end

    // R1: a restart always leaves the timer busy
    p_restart_busy_r1: assert property (@(posedge clk) disable iff (rst)
        restart |=> busy);

endmodule

// File: rtl/vterm_peak.sv
module vterm_peak
    import vterm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            upd,
    input  logic [MV_W-1:0] mv,
    output peak_t           pk
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            pk <= '0;
        else if (upd && (!pk.valid || mv > pk.mv))
            pk <= '{valid: 1'b1, mv: mv};
    end

    // R2: peak never decreases while held and not cleared
    p_peak_monotone_r2: assert property (@(posedge clk) disable iff (rst)
        pk.valid && !clear |=> pk.valid && pk.mv >= $past(pk.mv));

    // R9: clear empties the history
    p_clear_empty_r9: assert property (@(posedge clk) disable iff (rst)
        clear |=> !pk.valid);

endmodule

// File: rtl/vdrop_terminator.sv
module vdrop_terminator
    import vterm_pkg::*;
#(
    parameter int WIN_LO_MV      = 1000,
    parameter int WIN_HI_MV      = 2000,
    parameter int DROP_TENTHS_ND = 120,
    parameter int DROP_TENTHS_PK = 25,
    parameter int HOLD_LOW       = 150,
    parameter int HOLD_MID       = 300,
    parameter int HOLD_HIGH      = 75
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cycle_start,
    input  logic            hist_clr,
    input  logic            tick,
    input  logic [1:0]      mode_sel,
    input  logic            sample_vld,
    input  logic [MV_W-1:0] sample_mv,
    output logic            term_o,
    output logic [MV_W-1:0] peak_mv_o,
    output logic            peak_valid_o,
    output logic            holdoff_busy_o
);
    localparam int DW = MV_W + 4;
    localparam logic [MV_W-1:0] WLO    = MV_W'(WIN_LO_MV);
    localparam logic [MV_W-1:0] WHI    = MV_W'(WIN_HI_MV);
    localparam logic [DW-1:0]   THR_ND = DW'(DROP_TENTHS_ND);
    localparam logic [DW-1:0]   THR_PK = DW'(DROP_TENTHS_PK);
    localparam logic [DW-1:0]   TEN    = DW'(10);

    peak_t          pk;
    logic           busy;
    logic           in_win;
    logic           accept;
    logic           drop_hit;
    logic [DW-1:0]  diff10;
    logic [DW-1:0]  thr;
    logic           term_q;

    assign in_win = (sample_mv > WLO) && (sample_mv < WHI);
    assign accept = sample_vld && in_win && !hist_clr && !cycle_start;

    vterm_holdoff #(
        .LIM_LOW (HOLD_LOW),
        .LIM_MID (HOLD_MID),
        .LIM_HIGH(HOLD_HIGH)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .restart(cycle_start),
        .tick   (tick),
        .mode   (mode_sel),
        .busy   (busy)
    );

    vterm_peak u_peak (
        .clk  (clk),
        .rst  (rst),
        .clear(hist_clr || cycle_start),
        .upd  (accept),
        .mv   (sample_mv),
        .pk   (pk)
    );

    // drop compared in tenths of a millivolt
    always_comb begin
        thr      = is_neg_delta(mode_sel) ? THR_ND : THR_PK;
        diff10   = DW'(pk.mv - sample_mv) * TEN;
        drop_hit = pk.valid && (pk.mv >= sample_mv) && (diff10 >= thr);
    end

    always_ff @(posedge clk) begin
        if (rst || cycle_start)
            term_q <= 1'b0;
        else if (accept && !busy && drop_hit)
            term_q <= 1'b1;
    end

    assign term_o         = term_q;
    assign peak_mv_o      = pk.mv;
    assign peak_valid_o   = pk.valid;
    assign holdoff_busy_o = busy;

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        term_q && !cycle_start |=> term_q);

    p_restart_clear_r1: assert property (@(posedge clk) disable iff (rst)
        cycle_start |=> !term_q && !peak_valid_o);

    p_holdoff_mask_r7: assert property (@(posedge clk) disable iff (rst)
        !term_q && holdoff_busy_o |=> !term_q);

    p_window_r5: assert property (@(posedge clk) disable iff (rst)
        !term_q && sample_vld && (sample_mv <= WLO || sample_mv >= WHI) |=> !term_q);

    p_histclr_keeps_flag_r9: assert property (@(posedge clk) disable iff (rst)
        hist_clr && !cycle_start |=> term_q == $past(term_q));

endmodule

// File: tb/vdrop_terminator_test.sv
`timescale 1ns/1ps
module vdrop_terminator_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cycle_start, hist_clr, tick, sample_vld;
    logic [1:0]  mode_sel;
    logic [11:0] sample_mv;
    logic        term_o, peak_valid_o, holdoff_busy_o;
    logic [11:0] peak_mv_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    vdrop_terminator uut (
        .clk(clk), .rst(rst), .cycle_start(cycle_start), .hist_clr(hist_clr),
        .tick(tick), .mode_sel(mode_sel), .sample_vld(sample_vld),
        .sample_mv(sample_mv), .term_o(term_o), .peak_mv_o(peak_mv_o),
        .peak_valid_o(peak_valid_o), .holdoff_busy_o(holdoff_busy_o)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send(input int mv);
        sample_vld = 1'b1;
        sample_mv  = 12'(mv);
        step();
        sample_vld = 1'b0;
    endtask

    task automatic restart(input logic [1:0] m, input int n);
        mode_sel    = m;
        cycle_start = 1'b1;
        tick        = 1'b1;
        step();
        cycle_start = 1'b0;
        for (int i = 0; i < n; i++) step();
        tick = 1'b0;
    endtask

    task automatic t_reset();
        chk(term_o, 0, "R1 reset term");
        chk(peak_valid_o, 0, "R1 reset peak_valid");
        chk(holdoff_busy_o, 1, "R1 reset busy");
    endtask

    task automatic t_holdoff(input logic [1:0] m, input int lim, input string tag);
        restart(m, lim - 1);
        chk(holdoff_busy_o, 1, {"R6 busy before last tick ", tag});
        tick = 1'b1; step(); tick = 1'b0;
        chk(holdoff_busy_o, 0, {"R6 busy after last tick ", tag});
    endtask

    task automatic t_negdelta();
        restart(2'b10, 75);
        send(1500); send(1520);
        chk(peak_mv_o, 1520, "R2 peak rises");
        send(1510);
        chk(peak_mv_o, 1520, "R2 lower sample keeps peak");
        send(1509);
        chk(term_o, 0, "R3 drop 11 mV no term");
        send(1508);
        chk(term_o, 1, "R3 drop 12 mV term");
    endtask

    task automatic t_pvd();
        restart(2'b00, 150);
        send(1400); send(1398);
        chk(term_o, 0, "R4 drop 2 mV no term");
        send(1397);
        chk(term_o, 1, "R4 drop 3 mV term");
    endtask

    task automatic t_window();
        restart(2'b11, 75);
        send(1500);
        send(1000);
        chk(term_o, 0, "R5 1000 mV ignored");
        send(2000);
        chk(peak_mv_o, 1500, "R5 2000 mV not stored");
        send(1001);
        chk(term_o, 1, "R5 1001 mV counted");
    endtask

    task automatic t_masked();
        restart(2'b10, 0);
        send(1500); send(1400);
        chk(term_o, 0, "R7 masked during hold-off");
        chk(peak_mv_o, 1500, "R7 peak updated in hold-off");
        tick = 1'b1; for (int i = 0; i < 75; i++) step(); tick = 1'b0;
        send(1480);
        chk(term_o, 1, "R7 term after hold-off");
    endtask

    task automatic t_sticky();
        send(1600);
        chk(term_o, 1, "R8 stays on higher sample");
        hist_clr = 1'b1; step(); hist_clr = 1'b0;
        chk(term_o, 1, "R8 stays through hist_clr");
        cycle_start = 1'b1; step(); cycle_start = 1'b0;
        chk(term_o, 0, "R1 cycle_start clears term");
        chk(peak_valid_o, 0, "R1 cycle_start clears peak");
    endtask

    task automatic t_histclr();
        restart(2'b10, 75);
        send(1800);
        hist_clr = 1'b1; step(); hist_clr = 1'b0;
        chk(peak_valid_o, 0, "R9 peak dropped");
        chk(holdoff_busy_o, 0, "R9 hold-off untouched");
        send(1700);
        chk(peak_mv_o, 1700, "R9 new peak");
        chk(term_o, 0, "R9 no term vs old peak");
        send(1689);
        chk(term_o, 0, "R9 drop 11 from new peak");
        send(1688);
        chk(term_o, 1, "R9 drop 12 from new peak");
    endtask

    task automatic t_priority();
        restart(2'b10, 75);
        sample_vld = 1'b1; sample_mv = 12'd1900; hist_clr = 1'b1;
        step();
        sample_vld = 1'b0; hist_clr = 1'b0;
        chk(peak_valid_o, 0, "R10 sample with hist_clr discarded");
        sample_vld = 1'b1; sample_mv = 12'd1900; cycle_start = 1'b1;
        step();
        sample_vld = 1'b0; cycle_start = 1'b0;
        chk(peak_valid_o, 0, "R10 sample with cycle_start discarded");
    endtask

    initial begin
        rst = 1'b1; cycle_start = 1'b0; hist_clr = 1'b0; tick = 1'b0;
        sample_vld = 1'b0; sample_mv = '0; mode_sel = 2'b01;
        step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_holdoff(2'b01, 300, "mid");
        t_holdoff(2'b00, 150, "low");
        t_holdoff(2'b10, 75, "high");
        t_negdelta();
        t_pvd();
        t_window();
        t_masked();
        t_sticky();
        t_histclr();
        t_priority();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule